// File: doc/BRIEF.md
# Receive Descriptor Write-Back Generator

This block takes one received packet at a time as a byte stream and cuts it into fixed-size host receive buffers, one buffer per descriptor. For every buffer it builds a 128-bit write-back record: the low 64-bit word carries the buffer address handed in with the descriptor request, and the high word carries the byte count of that buffer, a 16-bit fragment checksum, a status byte, an errors byte and the VLAN tag. The records leave on a valid/ready port once the packet has ended, in buffer order.

Per-packet side information (buffer size, CRC-present flag, VLAN flag and tag, classification flags from the filters and checksum engines, and the errors byte) is taken on the first beat of the packet. A beat may be marked empty, which lets a packet end without a data byte on its last beat and lets a packet of zero bytes be signalled. The input stays closed from the beat after the last one until the last record of the packet has been taken. The address source is a valid/ready stream; its ready pulses each time a record is accepted.

The buffer size must be nonzero.

Top module: `rxd_wb_gen`

## Requirements
- R1: Every record except the packet's last has a length field (bits 79:64 of the record) equal to the buffer size. The last record holds the remaining bytes, so the lengths of all records of a packet sum to the number of bytes in the packet, CRC bytes included.
- R2: A packet of zero bytes yields no record, and the input reopens after it.
- R3: The checksum is the ones-complement sum, with end-around carry and starting from zero, of the packet taken as 16-bit big-endian words. The first byte of each pair is the high byte, and an odd final byte is padded with a zero low byte. When the CRC flag is set, the last four bytes of the packet are left out of the sum.
- R4: The checksum sits in bits 95:80 of the first record of a packet; every later record carries zero there.
- R5: Status bit 0 (record bit 96, done) is 1 in every record.
- R6: Status bit 1 (record bit 97, end of packet) is 1 only in the packet's last record.
- R7: Status bit 2 (bit 98) is 0. Status bits 4, 5, 6 and 7 (bits 100 to 103) copy flag inputs 0, 1, 2 and 3. The errors byte (bits 111:104) copies the errors input. Both apply to every record of the packet.
- R8: Status bit 3 (bit 99) is the VLAN-present flag. Bits 127:112 carry the VLAN tag when that flag is set and zero otherwise.
- R9: Bits 63:0 equal the address input in the cycle the record is accepted. The address ready output is high exactly in the cycles where a record is accepted.
- R10: While a record is offered and not accepted, bits 127:64 hold their value into the next cycle.
- R11: Records of a packet leave in buffer order after the packet's last beat. The input ready output is low from the cycle after that beat until the cycle after the last record is accepted.
- R12: Buffer size, CRC flag, VLAN flag and tag, flags and errors are sampled on the first beat only; changes on later beats have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat accepted when high with valid |
| in_data_i | input | 8 | Packet byte |
| in_sop_i | input | 1 | First beat of a packet |
| in_eop_i | input | 1 | Last beat of a packet |
| in_empty_i | input | 1 | Beat carries no byte |
| crc_incl_i | input | 1 | Last four bytes of the packet are CRC |
| vlan_present_i | input | 1 | Packet carried a VLAN tag |
| vlan_tag_i | input | 16 | VLAN tag value |
| pkt_flags_i | input | 4 | Classification flags for status bits 4 to 7 |
| pkt_err_i | input | 8 | Errors byte |
| buf_size_i | input | 16 | Buffer size in bytes, nonzero |
| addr_valid_i | input | 1 | Buffer address available |
| addr_ready_o | output | 1 | Buffer address consumed |
| addr_i | input | 64 | Buffer address for the next record |
| rec_valid_o | output | 1 | Record valid |
| rec_ready_i | input | 1 | Record accepted when high with valid |
| rec_o | output | 128 | Write-back record |

## Verification
The sweep runs packet lengths from zero to nineteen against buffer sizes from one to sixteen. It covers packets that end exactly on a buffer boundary, with and without an empty closing beat. A design that closes a buffer as soon as it fills would emit an extra zero-length record or set end of packet on the wrong record. Packets of one to five bytes with the CRC flag set show whether the four trailing bytes are dropped from the sum rather than the first four, and odd lengths show whether the final byte is padded on the correct side. The side inputs are scrambled on every non-first beat and the address and accept signals are throttled, so a design that samples side inputs late or changes its record while stalled gives wrong fields.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;

  localparam int unsigned FIELD_W = 16;

  typedef struct packed {
    logic pif;
    logic ipcs;
    logic l4cs;
    logic udpcs;
    logic vp;
    logic rsvd;
    logic eop;
    logic dd;
  } wb_status_t;

  typedef struct packed {
    logic [15:0] vlan;
    logic [7:0]  err;
    wb_status_t  status;
    logic [15:0] csum;
    logic [15:0] len;
  } wb_word1_t;

  typedef enum logic [1:0] {
    ST_RECV,
    ST_DRAIN,
    ST_EMIT
  } wb_state_t;

  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

endpackage

// File: rtl/rxwb_csum.sv
module rxwb_csum
  import rxwb_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clear_i,
  input  logic        byte_valid_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] sum_o
);

  logic [15:0] sum_q;
  logic [7:0]  hi_q;
  logic        pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q  <= '0;
      hi_q   <= '0;
      pend_q <= 1'b0;
    end else if (clear_i) begin
      sum_q  <= '0;
      hi_q   <= '0;
      pend_q <= 1'b0;
    end else if (byte_valid_i) begin
      if (pend_q) begin
        sum_q  <= oc_add(sum_q, {hi_q, byte_i});
        pend_q <= 1'b0;
      end else begin
        hi_q   <= byte_i;
        pend_q <= 1'b1;
      end
    end
  end

  // odd trailing byte folds in as the high half of a zero-padded word
  assign sum_o = pend_q ? oc_add(sum_q, {hi_q, 8'h00}) : sum_q;

  a_r3_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (sum_o == 16'h0000));

  a_r3_pair_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && !clear_i && pend_q) |=> !pend_q);

endmodule

// File: rtl/rxwb_crc_hold.sv
module rxwb_crc_hold #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned QW   = DEPTH * 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          push_i,
  input  logic [7:0]    push_byte_i,
  input  logic          pop_i,
  output logic          out_valid_o,
  output logic [7:0]    out_byte_o,
  output logic [CW-1:0] cnt_o
);

  logic [QW-1:0] q_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] top_idx;
  logic          full;

  assign full    = (cnt_q == CW'(DEPTH));
  assign top_idx = cnt_q - 1'b1;

  // newest byte at the low end; oldest held byte at index cnt-1
  assign out_valid_o = (push_i && full) || (pop_i && (cnt_q != '0));
  assign out_byte_o  = push_i ? q_q[QW-1 -: 8] : q_q[{top_idx, 3'b000} +: 8];
  assign cnt_o       = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (push_i) begin
      q_q <= (q_q << 8) | QW'(push_byte_i);
      if (!full) cnt_q <= cnt_q + 1'b1;
    end else if (pop_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));

  a_r3_no_push_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i));

endmodule

// File: rtl/rxwb_seg.sv
module rxwb_seg #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_i,
  input  logic             sop_i,
  input  logic             has_byte_i,
  input  logic [15:0]      buf_size_i,
  output logic [15:0]      bsz_o,
  output logic [15:0]      cur_len_o,
  output logic [CNT_W-1:0] nfull_o
);

  logic [15:0]      bsz_q, cur_q, bsz_eff, cur_b;
  logic [CNT_W-1:0] nf_q, nf_b;

  assign bsz_eff = sop_i ? buf_size_i : bsz_q;
  assign cur_b   = sop_i ? 16'd0 : cur_q;
  assign nf_b    = sop_i ? '0 : nf_q;

  // a full buffer is closed only when the next byte arrives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bsz_q <= '0;
      cur_q <= '0;
      nf_q  <= '0;
    end else if (beat_i) begin
      if (sop_i) bsz_q <= buf_size_i;
      if (has_byte_i) begin
        if (cur_b == bsz_eff) begin
          nf_q  <= nf_b + 1'b1;
          cur_q <= 16'd1;
        end else begin
          nf_q  <= nf_b;
          cur_q <= cur_b + 16'd1;
        end
      end else begin
        nf_q  <= nf_b;
        cur_q <= cur_b;
      end
    end
  end

  assign bsz_o     = bsz_q;
  assign cur_len_o = cur_q;
  assign nfull_o   = nf_q;

  a_r1_len_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_q <= bsz_q);

  a_r12_bsz_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i && sop_i) |-> (buf_size_i != 16'd0));

  a_r2_empty_no_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q == 16'd0) |-> (nf_q == '0));

endmodule

// File: rtl/rxd_wb_gen.sv
module rxd_wb_gen
  import rxwb_pkg::*;
#(
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned CRC_BYTES = 4,
  localparam int unsigned HCW      = $clog2(CRC_BYTES + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [7:0]   in_data_i,
  input  logic         in_sop_i,
  input  logic         in_eop_i,
  input  logic         in_empty_i,
  input  logic         crc_incl_i,
  input  logic         vlan_present_i,
  input  logic [15:0]  vlan_tag_i,
  input  logic [3:0]   pkt_flags_i,
  input  logic [7:0]   pkt_err_i,
  input  logic [15:0]  buf_size_i,
  input  logic         addr_valid_i,
  output logic         addr_ready_o,
  input  logic [63:0]  addr_i,
  output logic         rec_valid_o,
  input  logic         rec_ready_i,
  output logic [127:0] rec_o
);

  wb_state_t        state_q;
  logic [CNT_W-1:0] idx_q;
  logic             accept, has_byte, fire, last_rec;
  logic             crc_q, vp_q;
  logic [15:0]      tag_q;
  logic [3:0]       flags_q;
  logic [7:0]       err_q;

  logic [15:0]      bsz, cur_len, csum;
  logic [CNT_W-1:0] nfull;
  logic             h_clear, h_pop, h_out_valid;
  logic [7:0]       h_out_byte;
  logic [HCW-1:0]   h_cnt;
  logic             drain_done;
  wb_word1_t        w1;

  assign in_ready_o = (state_q == ST_RECV);
  assign accept     = in_valid_i && in_ready_o;
  assign has_byte   = accept && !in_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q   <= 1'b0;
      vp_q    <= 1'b0;
      tag_q   <= '0;
      flags_q <= '0;
      err_q   <= '0;
    end else if (accept && in_sop_i) begin
      crc_q   <= crc_incl_i;
      vp_q    <= vlan_present_i;
      tag_q   <= vlan_tag_i;
      flags_q <= pkt_flags_i;
      err_q   <= pkt_err_i;
    end
  end

  rxwb_seg #(.CNT_W(CNT_W)) i_seg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .beat_i     (accept),
    .sop_i      (in_sop_i),
    .has_byte_i (has_byte),
    .buf_size_i (buf_size_i),
    .bsz_o      (bsz),
    .cur_len_o  (cur_len),
    .nfull_o    (nfull)
  );

  // trailing CRC_BYTES are held back from the checksum until the end is known
  assign drain_done = crc_q || (h_cnt == '0);
  assign h_pop      = (state_q == ST_DRAIN) && !drain_done;
  assign h_clear    = (state_q == ST_DRAIN) && drain_done;

  rxwb_crc_hold #(.DEPTH(CRC_BYTES)) i_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (h_clear),
    .push_i      (has_byte),
    .push_byte_i (in_data_i),
    .pop_i       (h_pop),
    .out_valid_o (h_out_valid),
    .out_byte_o  (h_out_byte),
    .cnt_o       (h_cnt)
  );

  rxwb_csum i_csum (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (accept && in_sop_i),
    .byte_valid_i (h_out_valid),
    .byte_i       (h_out_byte),
    .sum_o        (csum)
  );

  assign rec_valid_o  = (state_q == ST_EMIT) && addr_valid_i;
  assign fire         = rec_valid_o && rec_ready_i;
  assign addr_ready_o = fire;
  assign last_rec     = (idx_q == nfull);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RECV;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_RECV: if (accept && in_eop_i) state_q <= ST_DRAIN;
        ST_DRAIN: if (drain_done) begin
          idx_q   <= '0;
          state_q <= (cur_len == 16'd0) ? ST_RECV : ST_EMIT;
        end
        ST_EMIT: if (fire) begin
          if (last_rec) state_q <= ST_RECV;
          else          idx_q   <= idx_q + 1'b1;
        end
        default: state_q <= ST_RECV;
      endcase
    end
  end

  always_comb begin
    w1               = '0;
    w1.len           = last_rec ? cur_len : bsz;
    w1.csum          = (idx_q == '0) ? csum : 16'h0000;
    w1.status.dd     = 1'b1;
    w1.status.eop    = last_rec;
    w1.status.rsvd   = 1'b0;
    w1.status.vp     = vp_q;
    w1.status.udpcs  = flags_q[0];
    w1.status.l4cs   = flags_q[1];
    w1.status.ipcs   = flags_q[2];
    w1.status.pif    = flags_q[3];
    w1.err           = err_q;
    w1.vlan          = vp_q ? tag_q : 16'h0000;
  end

  assign rec_o = {w1, addr_i};

  a_r11_in_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> !in_ready_o);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && !rec_ready_i) |=> ((state_q == ST_EMIT) && $stable(rec_o[127:64])));

  a_r6_eop_reopens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && rec_o[97]) |=> in_ready_o);

  a_r4_csum_first_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && (idx_q != '0)) |-> (rec_o[95:80] == 16'h0000));

  a_r11_idx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EMIT) |-> (idx_q <= nfull));

endmodule

// File: tb/test_rxd_wb_gen.sv
`timescale 1ns/1ps
module test_rxd_wb_gen;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, in_ready;
  logic [7:0]   in_data = '0;
  logic         in_sop = 1'b0, in_eop = 1'b0, in_empty = 1'b0;
  logic         crc_incl = 1'b0, vlan_present = 1'b0;
  logic [15:0]  vlan_tag = '0;
  logic [3:0]   pkt_flags = '0;
  logic [7:0]   pkt_err = '0;
  logic [15:0]  buf_size = 16'd1;
  logic         addr_valid = 1'b0, addr_ready;
  logic [63:0]  addr = '0;
  logic         rec_valid, rec_ready = 1'b0;
  logic [127:0] rec;

  int unsigned  n_vec = 0, n_bad = 0;
  logic [31:0]  rnd = 32'h1234_5678;
  bit           done = 1'b0;

  always #2 clk = ~clk;

  rxd_wb_gen i_rxd_wb_gen (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .in_sop_i(in_sop), .in_eop_i(in_eop), .in_empty_i(in_empty),
    .crc_incl_i(crc_incl), .vlan_present_i(vlan_present), .vlan_tag_i(vlan_tag),
    .pkt_flags_i(pkt_flags), .pkt_err_i(pkt_err), .buf_size_i(buf_size),
    .addr_valid_i(addr_valid), .addr_ready_o(addr_ready), .addr_i(addr),
    .rec_valid_o(rec_valid), .rec_ready_i(rec_ready), .rec_o(rec)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step_rnd();
    rnd = rnd ^ (rnd << 13);
    rnd = rnd ^ (rnd >> 17);
    rnd = rnd ^ (rnd << 5);
  endtask

  function automatic logic [7:0] pbyte(input int p, input int i);
    return 8'((p * 37 + i * 11 + 5) & 255);
  endfunction

  function automatic logic [15:0] exp_csum(input int p, input int n, input bit crc);
    int m;
    logic [15:0] s;
    logic [16:0] t;
    logic [15:0] w;
    m = crc ? ((n > 4) ? n - 4 : 0) : n;
    s = '0;
    for (int i = 0; i < m; i += 2) begin
      w = {pbyte(p, i), (i + 1 < m) ? pbyte(p, i + 1) : 8'h00};
      t = {1'b0, s} + {1'b0, w};
      s = t[15:0] + {15'd0, t[16]};
    end
    return s;
  endfunction

  // side inputs are real only on the first beat; scrambled otherwise (R12)
  task automatic drive_side(input bit real_v, input int bsz, input bit crc, input bit vp,
                            input logic [15:0] tag, input logic [3:0] fl, input logic [7:0] er);
    step_rnd();
    if (real_v) begin
      buf_size = 16'(bsz); crc_incl = crc; vlan_present = vp;
      vlan_tag = tag; pkt_flags = fl; pkt_err = er;
    end else begin
      buf_size = {12'd0, rnd[3:0]} + 16'd1; crc_incl = rnd[4]; vlan_present = rnd[5];
      vlan_tag = rnd[31:16]; pkt_flags = rnd[9:6]; pkt_err = rnd[17:10];
    end
  endtask

  task automatic send_pkt(input int p, input int n, input int bsz, input bit crc, input bit vp,
                          input logic [15:0] tag, input logic [3:0] fl, input logic [7:0] er,
                          input bit tail_empty);
    int nb;
    @(negedge clk);
    chk("R11 input open before packet", {63'd0, in_ready}, 64'd1);
    nb = (n == 0) ? 1 : (tail_empty ? n + 1 : n);
    for (int i = 0; i < nb; i++) begin
      step_rnd();
      while (rnd[2:0] == 3'd0) begin
        in_valid = 1'b0;
        @(negedge clk);
        step_rnd();
      end
      drive_side(i == 0, bsz, crc, vp, tag, fl, er);
      in_valid = 1'b1;
      in_sop   = (i == 0);
      in_eop   = (i == nb - 1);
      in_empty = (i >= n);
      in_data  = (i < n) ? pbyte(p, i) : rnd[7:0];
      @(negedge clk);
    end
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_empty = 1'b0;
  endtask

  task automatic collect(input int p, input int n, input int bsz, input bit crc, input bit vp,
                         input logic [15:0] tag, input logic [3:0] fl, input logic [7:0] er);
    int nd, k, lsum;
    bit pend_hold;
    logic [63:0] held, a;
    logic [15:0] cs;
    logic [15:0] elen;
    logic [7:0]  st;
    nd = (n == 0) ? 0 : (n + bsz - 1) / bsz;
    cs = exp_csum(p, n, crc);
    k = 0; lsum = 0; pend_hold = 1'b0;
    if (nd == 0) begin
      addr_valid = 1'b1; rec_ready = 1'b1;
      for (int c = 0; c < 8; c++) begin
        #1;
        chk("R2 no record for empty packet", {63'd0, rec_valid}, 64'd0);
        @(negedge clk);
      end
      chk("R2 input reopens after empty packet", {63'd0, in_ready}, 64'd1);
      addr_valid = 1'b0; rec_ready = 1'b0;
      return;
    end
    while (k < nd) begin
      step_rnd();
      rec_ready  = rnd[0] | rnd[1];
      addr_valid = rnd[2] | rnd[3] | rnd[4];
      a = {32'hB000_0000 + 32'(p), rnd};
      addr = a;
      #1;
      if (pend_hold) chk("R10 record held while stalled", rec[127:64], held);
      chk("R11 input closed while emitting", {63'd0, in_ready}, 64'd0);
      pend_hold = 1'b0;
      if (rec_valid) begin
        chk("R9 address ready matches accept", {63'd0, addr_ready}, {63'd0, rec_ready});
        if (rec_ready) begin
          elen = (k == nd - 1) ? 16'(n - (nd - 1) * bsz) : 16'(bsz);
          lsum += int'(rec[79:64]);
          chk("R12 length uses size from first beat", {48'd0, rec[79:64]}, {48'd0, elen});
          if (k == 0) chk("R3 checksum in first record", {48'd0, rec[95:80]}, {48'd0, cs});
          else        chk("R4 checksum zero in later record", {48'd0, rec[95:80]}, 64'd0);
          st = rec[103:96];
          chk("R5 done bit", {63'd0, st[0]}, 64'd1);
          chk("R6 end of packet bit", {63'd0, st[1]}, {63'd0, k == nd - 1});
          chk("R7 reserved bit and flags", {59'd0, st[7:4], st[2]}, {59'd0, fl, 1'b0});
          chk("R7 errors byte", {56'd0, rec[111:104]}, {56'd0, er});
          chk("R8 vlan flag and tag", {47'd0, st[3], rec[127:112]},
              {47'd0, vp, vp ? tag : 16'h0000});
          chk("R9 address echoed", rec[63:0], a);
          k++;
        end else begin
          pend_hold = 1'b1;
          held = rec[127:64];
        end
      end else begin
        chk("R9 no address pop without record", {63'd0, addr_ready}, 64'd0);
      end
      @(negedge clk);
    end
    rec_ready = 1'b0; addr_valid = 1'b0;
    #1;
    chk("R1 lengths sum to packet size", 64'(lsum), 64'(n));
    chk("R11 input reopens after last record", {62'd0, in_ready, rec_valid}, 64'd2);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int p;
    int sizes[6];
    sizes = '{1, 2, 3, 5, 8, 16};
    p = 0;
    repeat (3) @(negedge clk);
    addr_valid = 1'b1;
    #1;
    chk("R11 reset: input open", {63'd0, in_ready}, 64'd1);
    chk("R9 reset: no record, no address pop", {62'd0, rec_valid, addr_ready}, 64'd0);
    rst_n = 1'b1;
    addr_valid = 1'b0;
    @(negedge clk);
    foreach (sizes[s]) begin
      for (int n = 0; n < 20; n++) begin
        for (int c = 0; c < 2; c++) begin
          send_pkt(p, n, sizes[s], c[0], p[0], 16'(p * 97 + 3), 4'(p), 8'(~p),
                   p[1] && (n > 0));
          collect(p, n, sizes[s], c[0], p[0], 16'(p * 97 + 3), 4'(p), 8'(~p));
          p++;
        end
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule